// File: doc/BRIEF.md
# Streaming Merge Sorter

This block sorts fixed-size blocks of unsigned keys in a stream. Keys arrive one per cycle at most over a valid/ready handshake. They leave over a second valid/ready handshake, in ascending order within each block, with a flag on the final key of every block. The block has no software interface and no external memory. Each block holds exactly `N` keys, where `N` is a power of two.

The sorter is a chain of `log2(N)` merge stages. Stage `k` splits its incoming stream into alternating runs of `2^k` keys. It writes even-numbered runs into one FIFO and odd-numbered runs into a second FIFO. It then merges each pair of runs into a single ordered run of `2^(k+1)` keys. A stage begins a pair only when its first FIFO holds a whole run and the head of the partner run is present. While both runs still have keys, the stage compares the two FIFO heads and passes on the smaller one, taking the first FIFO's key when they are equal. Once one run is used up, the stage passes on the rest of the other run without comparing. Storage grows with `N` and logic grows with `log2(N)`, so one block takes time linear in `N`.

A stall at the output freezes the whole chain. No key is dropped or repeated.

Top module: `msort_top`

## Requirements
- R1: Within each block of `N` output keys, every key is greater than or equal to the key before it (unsigned compare).
- R2: Each output block holds exactly the multiset of keys from the matching input block, duplicates included. Blocks leave in the order they arrived, and no key appears beyond those supplied.
- R3: `out_last` is 1 on the `N`-th transferred output key of every block and 0 on every other transferred key.
- R4: While `out_valid` is 1 and `out_ready` is 0, the next cycle still shows `out_valid` at 1 with an unchanged `out_key`.
- R5: In the first cycle after synchronous reset is released, `out_valid` is 0 and `in_ready` is 1.
- R6: No key of a block is offered at the output until at least `N/2 + 1` keys of that block have been accepted. With only `N/2` keys supplied, `out_valid` stays 0 for as long as the input waits.
- R7: Input gaps (`in_valid` low) and output stalls, in any mix, change neither the order nor the content of the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input key present |
| in_ready | output | 1 | Sorter accepts the input key this cycle |
| in_key | input | KEY_W | Unsorted input key |
| out_valid | output | 1 | Sorted key present |
| out_ready | input | 1 | Consumer accepts the sorted key this cycle |
| out_key | output | KEY_W | Sorted output key |
| out_last | output | 1 | Marks the final key of a block |

## Verification
Inside each stage, new keys can be written into the partner-run FIFO in the same cycle that the merge is held by a downstream stall. If they are, the held head must not move, and the run-steering count must keep advancing. The bench provokes this by throttling `out_ready` on a fixed pattern in later blocks while input keys keep arriving, some of them with idle gaps. It judges the result on two counts: every stalled output key must reappear unchanged in the next cycle, and every block must still come out as the exact sorted copy of its input, with `out_last` on the final key.

// File: rtl/msort_pkg.sv
package msort_pkg;

    // Which FIFO an incoming run is steered into.
    typedef enum logic {
        LANE_A = 1'b0,
        LANE_B = 1'b1
    } lane_e;

    // Which FIFO head the merge forwards this cycle.
    typedef enum logic {
        SRC_A = 1'b0,
        SRC_B = 1'b1
    } src_e;

    // Merge selection: exhaust rules first, then compare; ties favour A.
    function automatic src_e pick_src(input logic a_done, input logic b_done,
                                      input logic a_le_b);
        if (b_done)      return SRC_A;
        else if (a_done) return SRC_B;
        else if (a_le_b) return SRC_A;
        else             return SRC_B;
    endfunction

    function automatic lane_e flip_lane(input lane_e l);
        return (l == LANE_A) ? LANE_B : LANE_A;
    endfunction

endpackage

// File: rtl/msort_fifo.sv
module msort_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         full,
    output logic         nempty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] cnt;

    assign head   = mem[rd_ptr];
    assign full   = (cnt == CW'(DEPTH));
    assign nempty = (cnt != '0);

    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (pop)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            case ({push, pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    // R2: the stage never writes a full FIFO nor reads an empty one
    a_r2_no_overflow: assert property (@(posedge clk) disable iff (rst)
        push |-> !full);
    a_r2_no_underflow: assert property (@(posedge clk) disable iff (rst)
        pop |-> nempty);

endmodule

// File: rtl/msort_cell.sv
module msort_cell
    import msort_pkg::*;
#(
    parameter int RUN   = 1,
    parameter int KEY_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [KEY_W-1:0] in_key,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [KEY_W-1:0] out_key
);
    localparam int CW = $clog2(RUN) + 1;

    // Run steering.
    lane_e         lane;
    logic [CW-1:0] fill_cnt;
    logic          a_full, a_ne, b_full, b_ne;
    logic [KEY_W-1:0] a_head, b_head;
    logic          push_a, push_b, accept;

    assign in_ready = (lane == LANE_A) ? !a_full : !b_full;
    assign accept   = in_valid && in_ready;
    assign push_a   = accept && (lane == LANE_A);
    assign push_b   = accept && (lane == LANE_B);

    always_ff @(posedge clk) begin
        if (rst) begin
            lane     <= LANE_A;
            fill_cnt <= '0;
        end else if (accept) begin
            if (fill_cnt == CW'(RUN - 1)) begin
                fill_cnt <= '0;
                lane     <= flip_lane(lane);
            end else begin
                fill_cnt <= fill_cnt + 1'b1;
            end
        end
    end

    // Merge of one run pair.
    logic          active;
    logic [CW-1:0] a_left, b_left, cur_a, cur_b, nxt_a, nxt_b;
    logic          start, go, fire, pop_a, pop_b;
    src_e          src;

    assign start = !active && a_full && b_ne;
    assign go    = active || start;
    assign cur_a = active ? a_left : CW'(RUN);
    assign cur_b = active ? b_left : CW'(RUN);
    assign src   = pick_src(cur_a == '0, cur_b == '0, a_head <= b_head);

    assign out_valid = go && ((cur_b == '0) || b_ne);
    assign out_key   = (src == SRC_A) ? a_head : b_head;
    assign fire      = out_valid && out_ready;
    assign pop_a     = fire && (src == SRC_A);
    assign pop_b     = fire && (src == SRC_B);
    assign nxt_a     = cur_a - CW'(pop_a);
    assign nxt_b     = cur_b - CW'(pop_b);

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            a_left <= '0;
            b_left <= '0;
        end else if (fire) begin
            active <= (nxt_a != '0) || (nxt_b != '0);
            a_left <= nxt_a;
            b_left <= nxt_b;
        end
    end

    msort_fifo #(.DEPTH(RUN), .W(KEY_W)) i_fifo_a (
        .clk(clk), .rst(rst), .push(push_a), .wdata(in_key), .pop(pop_a),
        .head(a_head), .full(a_full), .nempty(a_ne)
    );

    msort_fifo #(.DEPTH(RUN), .W(KEY_W)) i_fifo_b (
        .clk(clk), .rst(rst), .push(push_b), .wdata(in_key), .pop(pop_b),
        .head(b_head), .full(b_full), .nempty(b_ne)
    );

    // Checker state: previous key forwarded within the current pair.
    logic             mid_pair;
    logic [KEY_W-1:0] prev_key;

    always_ff @(posedge clk) begin
        if (rst) begin
            mid_pair <= 1'b0;
            prev_key <= '0;
        end else if (fire) begin
            mid_pair <= (nxt_a != '0) || (nxt_b != '0);
            prev_key <= out_key;
        end
    end

    // R1: a merged run leaves the stage in non-decreasing order
    a_r1_pair_ordered: assert property (@(posedge clk) disable iff (rst)
        (out_valid && mid_pair) |-> (out_key >= prev_key));

    // R4: a stalled offer holds its key
    a_r4_cell_hold: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_key)));

endmodule

// File: rtl/msort_top.sv
module msort_top #(
    parameter int N     = 64,
    parameter int KEY_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [KEY_W-1:0] in_key,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [KEY_W-1:0] out_key,
    output logic             out_last
);
    localparam int STAGES = $clog2(N);
    localparam int LW     = (STAGES > 0) ? STAGES : 1;

    logic             v [STAGES+1];
    logic             r [STAGES+1];
    logic [KEY_W-1:0] k [STAGES+1];

    assign v[0]     = in_valid;
    assign k[0]     = in_key;
    assign in_ready = r[0];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        msort_cell #(.RUN(1 << s), .KEY_W(KEY_W)) i_cell (
            .clk      (clk),
            .rst      (rst),
            .in_valid (v[s]),
            .in_ready (r[s]),
            .in_key   (k[s]),
            .out_valid(v[s+1]),
            .out_ready(r[s+1]),
            .out_key  (k[s+1])
        );
    end

    assign out_valid     = v[STAGES];
    assign out_key       = k[STAGES];
    assign r[STAGES]     = out_ready;

    // Position of the next output key inside its block.
    logic [LW-1:0] out_pos;

    always_ff @(posedge clk) begin
        if (rst)                        out_pos <= '0;
        else if (out_valid && out_ready) out_pos <= out_pos + 1'b1;
    end

    assign out_last = out_valid && (out_pos == LW'(N - 1));

    // R4: backpressure holds the offered key at the block edge
    a_r4_out_hold: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_key) && $stable(out_last)));

    // R3: a block boundary is flagged only on an offered key
    a_r3_last_valid: assert property (@(posedge clk) disable iff (rst)
        out_last |-> out_valid);

endmodule

// File: tb/test_msort_top.sv
module test_msort_top;
    localparam int N  = 16;
    localparam int KW = 8;
    localparam int NB = 6;

    localparam logic [KW-1:0] TAB [3][N] = '{
        '{8'h3C, 8'h11, 8'hA7, 8'h05, 8'hF0, 8'h2B, 8'h77, 8'h11,
          8'h90, 8'h01, 8'hDE, 8'h46, 8'h5A, 8'hC3, 8'h08, 8'h6E},
        '{8'h00, 8'hFF, 8'h80, 8'h7F, 8'h01, 8'hFE, 8'h40, 8'hBF,
          8'h20, 8'hDF, 8'h10, 8'hEF, 8'h08, 8'hF7, 8'h04, 8'hFB},
        '{8'h33, 8'h22, 8'h33, 8'h11, 8'h22, 8'h33, 8'h11, 8'h44,
          8'h22, 8'h11, 8'h44, 8'h33, 8'h00, 8'h44, 8'h00, 8'h22}
    };

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          rst, in_valid, in_ready, out_valid, out_ready, out_last;
    logic [KW-1:0] in_key, out_key;

    msort_top #(.N(N), .KEY_W(KW)) i_msort_top (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_key(in_key), .out_valid(out_valid), .out_ready(out_ready),
        .out_key(out_key), .out_last(out_last)
    );

    int n_chk = 0;
    int n_bad = 0;
    logic [KW-1:0] stim [NB][N];
    logic [KW-1:0] expv [NB][N];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic push_key(input logic [KW-1:0] kv);
        bit acc;
        in_valid = 1'b1;
        in_key   = kv;
        do begin
            @(negedge clk);
            acc = in_ready;
            @(posedge clk);
            #1;
        end while (!acc);
        in_valid = 1'b0;
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        finish_run();
    end

    initial begin
        // Build stimulus: table rows plus computed patterns.
        for (int b = 0; b < 3; b++)
            for (int i = 0; i < N; i++) stim[b][i] = TAB[b][i];
        for (int i = 0; i < N; i++) begin
            stim[3][i] = KW'((N - 1 - i) * 9);   // reverse order
            stim[4][i] = 8'h5A;                  // all equal
            stim[5][i] = KW'(i * 16);            // already sorted
        end
        // Expected: ascending copy of each block.
        for (int b = 0; b < NB; b++) begin
            for (int i = 0; i < N; i++) expv[b][i] = stim[b][i];
            for (int i = 1; i < N; i++)
                for (int j = i; j > 0; j--)
                    if (expv[b][j-1] > expv[b][j]) begin
                        logic [KW-1:0] t;
                        t = expv[b][j]; expv[b][j] = expv[b][j-1]; expv[b][j-1] = t;
                    end
        end

        rst = 1'b1; in_valid = 1'b0; in_key = '0; out_ready = 1'b1;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk(out_valid == 1'b0, "R5 out_valid", int'(out_valid), 0);
        chk(in_ready == 1'b1, "R5 in_ready", int'(in_ready), 1);
        @(posedge clk); #1;

        fork
            begin : driver
                bit seen;
                for (int i = 0; i < N/2; i++) push_key(stim[0][i]);
                seen = 1'b0;
                repeat (40) begin
                    @(negedge clk);
                    if (out_valid) seen = 1'b1;
                end
                chk(!seen, "R6 early output", int'(seen), 0);
                @(posedge clk); #1;
                for (int i = N/2; i < N; i++) push_key(stim[0][i]);
                for (int b = 1; b < NB; b++)
                    for (int i = 0; i < N; i++) begin
                        push_key(stim[b][i]);
                        if ((b == 1 || b == 2 || b == 4) && (i % 5 == 4)) begin
                            @(posedge clk); #1;   // R7: input gap
                        end
                    end
            end
            begin : monitor
                int blk, idx, cyc;
                bit stalled;
                logic [KW-1:0] hk;
                blk = 0; idx = 0; cyc = 0; stalled = 1'b0; hk = '0;
                while (blk < NB) begin
                    @(negedge clk);
                    if (stalled)
                        chk(out_valid && out_key == hk, "R4 hold", int'(out_key), int'(hk));
                    stalled = 1'b0;
                    if (out_valid && out_ready) begin
                        // R1 R2 R7: exact sorted copy of the input block
                        chk(out_key == expv[blk][idx], "R1 R2 R7 key",
                            int'(out_key), int'(expv[blk][idx]));
                        chk(out_last == (idx == N - 1), "R3 last",
                            int'(out_last), int'(idx == N - 1));
                        idx++;
                        if (idx == N) begin idx = 0; blk++; end
                    end else if (out_valid) begin
                        stalled = 1'b1;
                        hk = out_key;
                    end
                    @(posedge clk); #1;
                    cyc++;
                    out_ready = (blk < 2) || ((cyc % 3) != 1) && ((cyc % 7) != 2);
                end
                out_ready = 1'b1;
            end
        join

        begin
            bit extra;
            extra = 1'b0;
            repeat (40) begin
                @(negedge clk);
                if (out_valid) extra = 1'b1;
            end
            chk(!extra, "R2 no extra key", int'(extra), 0);
        end
        finish_run();
    end

endmodule